// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block is the combinational shifter that sits in front of an ALU and conditions its second operand. It takes a 32-bit value and applies one of five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. It returns the shifted value together with the carry bit that a flag-setting operation would record.

The shift distance comes from one of two sources, chosen per operation. The first source is a 5-bit immediate field. The second is the least significant byte of a register, so register distances run from 0 to 255.

Some immediate encodings are reused. An immediate distance of zero means "shift by 32" for both right shifts. For rotate right, an immediate zero selects the rotate-through-carry kind. Register distances of 32 or more saturate in the way each kind defines, and the carry out follows the same rules.

Top module: `barrel_operand_shifter`

## Requirements
- R1: A resolved shift distance of 0 leaves the value unchanged and copies carry_i to carry_o. This covers any kind with a register distance of 0, and the left kind (kind_i = 2'b00) with an immediate distance of 0.
- R2: Left shift (kind_i = 2'b00) by n in 1..31 moves the value n places up and fills with zeros. The carry is the last bit shifted out, which is operand bit 32-n.
- R3: Logical right shift (kind_i = 2'b01) by n in 1..31 fills from the top with zeros. The carry is operand bit n-1.
- R4: Arithmetic right shift (kind_i = 2'b10) by n in 1..31 fills from the top with copies of operand bit 31. The carry is operand bit n-1.
- R5: Rotate right (kind_i = 2'b11) by a distance that is not a multiple of 32 moves bits that leave the bottom back in at the top. The carry equals result bit 31.
- R6: Rotate right with an immediate distance of 0 is the rotate-through-carry kind. The result is {carry_i, operand[31:1]} and the carry is operand bit 0.
- R7: An immediate distance of 0 with either right shift kind acts as a shift by 32. Logical right gives 0 with carry operand bit 31. Arithmetic right gives 32 copies of bit 31 with carry equal to bit 31.
- R8: With a register distance, a left or logical right shift by exactly 32 gives 0. The carry is operand bit 0 for the left shift and operand bit 31 for the logical right shift. A distance above 32 gives 0 with carry 0.
- R9: With a register distance of 32 or more, an arithmetic right shift fills every bit with operand bit 31, and the carry equals that bit.
- R10: A register distance for rotate right is taken modulo 32. A non-zero multiple of 32 returns the value unchanged, with carry equal to operand bit 31.
- R11: When amt_from_reg_i is 1, the distance is reg_amt_i and imm_amt_i has no effect. When it is 0, the distance is imm_amt_i and reg_amt_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_from_reg_i | input | 1 | 1 selects the register byte as the distance, 0 selects the immediate |
| imm_amt_i | input | 5 | Immediate shift distance |
| reg_amt_i | input | 8 | Low byte of the register that supplies the distance |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The assertions in the top module are evaluated only when every input is a known 0 or 1. They also assume the data width is a power of two, which the modulo rule for rotation needs. The bench drives all inputs to defined values before its first check, and it changes them only at rising clock edges. It samples the outputs at falling edges, so each combinational result has settled before it is checked. The random distances are weighted toward 0, 1, 31, 32, 33 and 255, which puts the saturation and reinterpretation corners into the random mix as well as into the directed sweeps.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 5;
    localparam int REGAM_W = 8;
    localparam int LOG_W   = $clog2(DATA_W);
    localparam int CNT_W   = (REGAM_W > LOG_W + 1) ? REGAM_W : LOG_W + 1;

    typedef enum logic [1:0] {
        KIND_LSL = 2'b00,
        KIND_LSR = 2'b01,
        KIND_ASR = 2'b10,
        KIND_ROR = 2'b11
    } shf_kind_e;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_ASR,
        OP_ROR,
        OP_RRX
    } shf_op_e;

    typedef struct packed {
        shf_op_e            op;
        logic [CNT_W-1:0]   amt;
    } shf_cmd_t;

    function automatic shf_op_e kind_to_op(input shf_kind_e k);
        case (k)
            KIND_LSL: return OP_LSL;
            KIND_LSR: return OP_LSR;
            KIND_ASR: return OP_ASR;
            default:  return OP_ROR;
        endcase
    endfunction

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
    import shf_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int IW  = IMM_W,
    parameter int RW  = REGAM_W,
    parameter int CW  = CNT_W
) (
    input  shf_kind_e       kind_i,
    input  logic            from_reg_i,
    input  logic [IW-1:0]   imm_i,
    input  logic [RW-1:0]   reg_i,
    output shf_op_e         op_o,
    output logic [CW-1:0]   amt_o
);

    localparam logic [CW-1:0] FULL_C = CW'(DW);

    always_comb begin
        amt_o = from_reg_i ? CW'(reg_i) : CW'(imm_i);
        op_o  = kind_to_op(kind_i);
        if (amt_o == '0) begin
            if (!from_reg_i && (kind_i == KIND_LSR || kind_i == KIND_ASR)) begin
                amt_o = FULL_C;
            end else if (!from_reg_i && kind_i == KIND_ROR) begin
                op_o = OP_RRX;
            end else begin
                op_o = OP_PASS;
            end
        end
    end

endmodule

// File: rtl/shf_linear.sv
module shf_linear
    import shf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  shf_op_e         op_i,
    input  logic [CW-1:0]   amt_i,
    input  logic [DW-1:0]   val_i,
    output logic [DW-1:0]   res_o,
    output logic            cry_o
);

    localparam logic [CW-1:0] FULL_C = CW'(DW);
    localparam logic [CW-1:0] OVER_C = CW'(DW + 1);

    logic [CW-1:0]  sat_amt;
    logic [CW-1:0]  asr_amt;
    logic [DW:0]    lsl_w;
    logic [DW:0]    lsr_w;
    logic [DW:0]    asr_w;

    always_comb begin
        sat_amt = (amt_i > FULL_C) ? OVER_C : amt_i;
        asr_amt = (amt_i > FULL_C) ? FULL_C : amt_i;
        lsl_w   = {1'b0, val_i} << sat_amt;
        lsr_w   = {val_i, 1'b0} >> sat_amt;
        asr_w   = $unsigned($signed({val_i, 1'b0}) >>> asr_amt);
        case (op_i)
            OP_LSL: begin
                res_o = lsl_w[DW-1:0];
                cry_o = lsl_w[DW];
            end
            OP_LSR: begin
                res_o = lsr_w[DW:1];
                cry_o = lsr_w[0];
            end
            default: begin
                res_o = asr_w[DW:1];
                cry_o = asr_w[0];
            end
        endcase
    end

endmodule

// File: rtl/shf_rotate.sv
module shf_rotate
    import shf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  shf_op_e         op_i,
    input  logic [CW-1:0]   amt_i,
    input  logic [DW-1:0]   val_i,
    input  logic            cry_i,
    output logic [DW-1:0]   res_o,
    output logic            cry_o
);

    localparam int LW = $clog2(DW);

    logic [LW-1:0]   rot;
    logic [2*DW-1:0] dbl;

    always_comb begin
        rot = amt_i[LW-1:0];
        dbl = {val_i, val_i} >> rot;
        if (op_i == OP_RRX) begin
            res_o = {cry_i, val_i[DW-1:1]};
            cry_o = val_i[0];
        end else begin
            res_o = dbl[DW-1:0];
            cry_o = dbl[DW-1];
        end
    end

endmodule

// File: rtl/barrel_operand_shifter.sv
module barrel_operand_shifter
    import shf_pkg::*;
(
    input  logic [DATA_W-1:0]  operand_i,
    input  logic [1:0]         kind_i,
    input  logic               amt_from_reg_i,
    input  logic [IMM_W-1:0]   imm_amt_i,
    input  logic [REGAM_W-1:0] reg_amt_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               carry_o
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DATA_W);

    shf_cmd_t           cmd;
    shf_op_e            dec_op;
    logic [CNT_W-1:0]   dec_amt;
    logic [DATA_W-1:0]  lin_res;
    logic               lin_cry;
    logic [DATA_W-1:0]  rot_res;
    logic               rot_cry;

    shf_amount_decode #(
        .DW(DATA_W), .IW(IMM_W), .RW(REGAM_W), .CW(CNT_W)
    ) u_dec (
        .kind_i     (shf_kind_e'(kind_i)),
        .from_reg_i (amt_from_reg_i),
        .imm_i      (imm_amt_i),
        .reg_i      (reg_amt_i),
        .op_o       (dec_op),
        .amt_o      (dec_amt)
    );

    assign cmd.op  = dec_op;
    assign cmd.amt = dec_amt;

    shf_linear #(.DW(DATA_W), .CW(CNT_W)) u_lin (
        .op_i  (cmd.op),
        .amt_i (cmd.amt),
        .val_i (operand_i),
        .res_o (lin_res),
        .cry_o (lin_cry)
    );

    shf_rotate #(.DW(DATA_W), .CW(CNT_W)) u_rot (
        .op_i  (cmd.op),
        .amt_i (cmd.amt),
        .val_i (operand_i),
        .cry_i (carry_i),
        .res_o (rot_res),
        .cry_o (rot_cry)
    );

    always_comb begin
        case (cmd.op)
            OP_PASS: begin
                result_o = operand_i;
                carry_o  = carry_i;
            end
            OP_ROR, OP_RRX: begin
                result_o = rot_res;
                carry_o  = rot_cry;
            end
            default: begin
                result_o = lin_res;
                carry_o  = lin_cry;
            end
        endcase
    end

    // Output checks, active only while every input is a known value.
    always_comb begin
        if (!$isunknown({operand_i, kind_i, amt_from_reg_i, imm_amt_i, reg_amt_i, carry_i})) begin
            // R1: a zero distance leaves value and carry untouched
            a_r1_pass_through: assert (!(amt_from_reg_i && reg_amt_i == '0)
                                       || (result_o == operand_i && carry_o == carry_i))
                else $error("R1 zero register distance altered data");
            // R6: rotate through carry
            a_r6_rrx: assert (!(!amt_from_reg_i && imm_amt_i == '0 && kind_i == 2'b11)
                              || (result_o[DATA_W-1] == carry_i && carry_o == operand_i[0]))
                else $error("R6 rotate through carry mismatch");
            // R5: rotation keeps the population count, carry follows bit 31
            a_r5_ror_popcount: assert (!(kind_i == 2'b11 && (amt_from_reg_i || imm_amt_i != '0))
                                       || ($countones(result_o) == $countones(operand_i)
                                           && (carry_o == result_o[DATA_W-1]
                                               || (amt_from_reg_i && reg_amt_i == '0))))
                else $error("R5 rotation lost bits");
            // R4: arithmetic shift keeps the sign
            a_r4_asr_sign: assert (kind_i != 2'b10 || result_o[DATA_W-1] == operand_i[DATA_W-1])
                else $error("R4 sign bit changed");
            // R8: left shift past the width clears value and carry
            a_r8_lsl_wide_zero: assert (!(kind_i == 2'b00 && amt_from_reg_i
                                          && CNT_W'(reg_amt_i) > FULL_C)
                                        || (result_o == '0 && !carry_o))
                else $error("R8 wide left shift not cleared");
        end
    end

endmodule

// File: tb/tb_barrel_operand_shifter.sv
module tb_barrel_operand_shifter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [1:0]  kind_i = '0;
    logic        amt_from_reg_i = 1'b0;
    logic [4:0]  imm_amt_i = '0;
    logic [7:0]  reg_amt_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    barrel_operand_shifter dut (
        .operand_i      (operand_i),
        .kind_i         (kind_i),
        .amt_from_reg_i (amt_from_reg_i),
        .imm_amt_i      (imm_amt_i),
        .reg_amt_i      (reg_amt_i),
        .carry_i        (carry_i),
        .result_o       (result_o),
        .carry_o        (carry_o)
    );

    // One-place-at-a-time reference model, returns {carry, value}.
    function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
                                          input logic src, input logic [4:0] im,
                                          input logic [7:0] rg, input logic c);
        int n;
        logic [31:0] x;
        logic cy;
        x = v;
        cy = c;
        n = src ? int'(rg) : int'(im);
        if (!src && im == 0) begin
            if (k == 2'b11) return {v[0], c, v[31:1]};
            if (k == 2'b01 || k == 2'b10) n = 32;
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin cy = x[31]; x = {x[30:0], 1'b0}; end
                2'b01: begin cy = x[0];  x = {1'b0, x[31:1]}; end
                2'b10: begin cy = x[0];  x = {x[31], x[31:1]}; end
                default: begin cy = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {cy, x};
    endfunction

    function automatic string tag(input logic [1:0] k, input logic src,
                                  input logic [4:0] im, input logic [7:0] rg);
        int n;
        n = src ? int'(rg) : int'(im);
        if (!src && im == 0 && k == 2'b11) return "R6";
        if (!src && im == 0 && k != 2'b00) return "R7";
        if (n == 0) return "R1";
        if (k == 2'b11) return (n % 32 == 0) ? "R10" : (n > 31 ? "R10" : "R5");
        if (n < 32) return (k == 2'b00) ? "R2" : (k == 2'b01) ? "R3" : "R4";
        return (k == 2'b10) ? "R9" : "R8";
    endfunction

    task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic src,
                         input logic [4:0] im, input logic [7:0] rg, input logic c,
                         input string req);
        logic [32:0] exp;
        @(posedge clk);
        operand_i = v; kind_i = k; amt_from_reg_i = src;
        imm_amt_i = im; reg_amt_i = rg; carry_i = c;
        @(negedge clk);
        exp = model(v, k, src, im, rg, c);
        n_checks++;
        if ({carry_o, result_o} !== exp) begin
            n_errors++;
            $display("FAIL %s: kind=%0d src=%0d imm=%0d reg=%0d op=%h cin=%0d actual=%0d/%h expected=%0d/%h",
                     req, k, src, im, rg, v, c, carry_o, result_o, exp[32], exp[31:0]);
        end
    endtask

    function automatic logic [7:0] pick_amt();
        case ($urandom % 8)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd31;
            3: return 8'd32;
            4: return 8'd33;
            5: return 8'd255;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'hFFFF_FFFF;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: all-zero inputs give zero outputs (R1)
        @(negedge clk);
        n_checks++;
        if (result_o !== 32'h0 || carry_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: idle actual=%0d/%h expected=0/00000000", carry_o, result_o);
        end
        // Register distances 0..40 plus large values, every kind (R1-R5, R8, R9, R10)
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 44; a++) begin
                    logic [7:0] amt;
                    amt = (a < 41) ? 8'(a) : (a == 41) ? 8'd64 : (a == 42) ? 8'd96 : 8'd255;
                    apply(pats[p], 2'(k), 1'b1, 5'(a), amt, 1'(a),
                          tag(2'(k), 1'b1, 5'(a), amt));
                end
        // Immediate distances 0..31, every kind, both carry values (R6, R7, R11)
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 32; a++)
                    for (int c = 0; c < 2; c++)
                        apply(pats[p], 2'(k), 1'b0, 5'(a), 8'(8'hC0 | a), 1'(c),
                              (a == 0) ? tag(2'(k), 1'b0, 5'(a), 8'd0) : "R11");
        // Explicit corners
        apply(32'h0000_0001, 2'b00, 1'b1, 5'd3, 8'd32, 1'b0, "R8");
        apply(32'h8000_0000, 2'b01, 1'b1, 5'd3, 8'd32, 1'b0, "R8");
        apply(32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd200, 1'b0, "R9");
        apply(32'h8000_0001, 2'b11, 1'b1, 5'd0, 8'd64, 1'b0, "R10");
        apply(32'h1234_5678, 2'b11, 1'b0, 5'd0, 8'd4, 1'b1, "R6");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] v;
            logic [1:0]  k;
            logic        s;
            logic [7:0]  rg;
            logic [4:0]  im;
            v  = $urandom;
            k  = 2'($urandom);
            s  = 1'($urandom);
            rg = pick_amt();
            im = 5'(pick_amt());
            apply(v, k, s, im, rg, 1'($urandom), s ? tag(k, s, im, rg) : "R11");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule